// File: doc/BRIEF.md
# Mode-Selectable Array Multiplier

This block multiplies two N-bit operands and returns the full 2N-bit product. Its datapath is a regular array. A grid of AND gates forms one partial-product bit for every pair of operand bits. Rows of full-adder cells then fold those bits, one multiplier row at a time, into a running sum. Every row adder starts with a zero carry-in, so each row costs one full adder more than the bare minimum.

A single mode input selects how the operands are read: 0 means unsigned and 1 means two's complement. In two's-complement mode the array does not sign-extend its rows. Instead it complements each partial-product bit that mixes exactly one operand sign bit with an ordinary bit, and injects a constant one at column N. It then flips the top bit of the sum. The term built from both sign bits keeps its positive weight and is left as it is.

An optional output register captures the product on the rising clock edge, and an active-low asynchronous reset clears it. With the register removed, the block is purely combinational.

Top module: `tc_array_mult`

## Requirements
- R1: With mode_i = 0, product_o equals the unsigned product of a_i and b_i, written in 2N bits.
- R2: With mode_i = 1, product_o equals the two's-complement product of a_i and b_i, written as a 2N-bit two's-complement value whose top bit has negative weight.
- R3: If either operand is all zeros, product_o is all zeros in both modes.
- R4: In mode 1, the most negative operand times itself (bit N-1 set, all other bits clear, for both operands) gives exactly 2^(2N-2), so bit 2N-2 is set and every other bit is clear.
- R5: In mode 0, all-ones times all-ones gives (2^N-1)^2, which is 0xFE01 for N = 8.
- R6: When the top bits of both operands are 0, the result is the same in both modes.
- R7: With OUT_REG = 1, product_o shows the result for the operands present at a rising clock edge, starting at that edge. While rst_n is low, product_o is zero.
- R8: Multiplying by one returns the other operand. In mode 0 it is zero-extended to 2N bits, and in mode 1 it is sign-extended to 2N bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| mode_i | input | 1 | Operand format: 0 unsigned, 1 two's complement |
| a_i | input | N | Multiplicand |
| b_i | input | N | Multiplier |
| product_o | output | 2N | Product |

## Verification
The datapath has no internal state, so a faulty cell, a missed inversion or a wrong constant shows up as a wrong product bit in the cycle the operands are captured. A wrong constant or top-bit flip gives an error of 2^N or 2^(2N-1) on every signed case. A mixed-term inversion that is missing only shows when the operand sign bits and the other bits interact, which is why the operand space is swept exhaustively at N = 4 and sampled densely at N = 8. Faults in the register path show up as a product that arrives one edge late or early, or as a non-zero value during reset.

// File: rtl/tc_mult_pkg.sv
package tc_mult_pkg;

    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_SIGNED   = 1'b1
    } mult_mode_e;

    // True when exactly one index addresses a sign bit: such terms are complemented in signed mode
    function automatic bit is_mixed_sign(input int row, input int col, input int width);
        return (row == width - 1) != (col == width - 1);
    endfunction

endpackage

// File: rtl/tc_fa_cell.sv
module tc_fa_cell (
    input  logic x_i,
    input  logic y_i,
    input  logic ci_i,
    output logic s_o,
    output logic co_o
);
    assign s_o  = x_i ^ y_i ^ ci_i;
    assign co_o = (x_i & y_i) | (ci_i & (x_i ^ y_i));
endmodule

// File: rtl/tc_pp_gen.sv
module tc_pp_gen
    import tc_mult_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           signed_i,
    input  logic [N-1:0]   a_i,
    input  logic [N-1:0]   b_i,
    output logic [N*N-1:0] pp_o     // row r occupies pp_o[r*N +: N], bit c has weight 2^(r+c)
);
    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            localparam bit MIXED = is_mixed_sign(r, c, N);
            if (MIXED) begin : g_flip
                assign pp_o[r*N + c] = (a_i[c] & b_i[r]) ^ signed_i;
            end else begin : g_keep
                assign pp_o[r*N + c] = a_i[c] & b_i[r];
            end
        end
    end
endmodule

// File: rtl/tc_row_adder.sv
module tc_row_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] row_i,
    output logic [W:0]   sum_o
);
    logic [W:0] carry;

    // Zero carry-in: the first cell of every row absorbs a constant zero
    assign carry[0] = 1'b0;

    for (genvar k = 0; k < W; k++) begin : g_cell
        tc_fa_cell u_fa (
            .x_i  (acc_i[k]),
            .y_i  (row_i[k]),
            .ci_i (carry[k]),
            .s_o  (sum_o[k]),
            .co_o (carry[k+1])
        );
    end

    assign sum_o[W] = carry[W];
endmodule

// File: rtl/tc_array_mult.sv
module tc_array_mult
    import tc_mult_pkg::*;
#(
    parameter int N       = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode_i,
    input  logic [N-1:0]   a_i,
    input  logic [N-1:0]   b_i,
    output logic [2*N-1:0] product_o
);
    localparam int PW = 2 * N;

    logic          is_signed;
    logic [N*N-1:0] pp;
    logic [PW-1:0] raw_sum;
    logic [PW-1:0] prod_c;

    assign is_signed = (mult_mode_e'(mode_i) == MODE_SIGNED);

    tc_pp_gen #(.N(N)) u_ppgen (
        .signed_i (is_signed),
        .a_i      (a_i),
        .b_i      (b_i),
        .pp_o     (pp)
    );

    // Running sum: stage i holds rows 0..i; upper unused bits are zero
    for (genvar i = 0; i < N; i++) begin : g_stage
        logic [PW-1:0] acc_s;
        if (i == 0) begin : g_seed
            // Row 0 plus the signed-mode constant at column N
            assign acc_s[N-1:0] = pp[N-1:0];
            assign acc_s[N]     = is_signed;
            assign acc_s[PW-1:N+1] = '0;
        end else begin : g_add
            logic [N:0] row_sum;
            tc_row_adder #(.W(N)) u_row (
                .acc_i (g_stage[i-1].acc_s[i+N-1:i]),
                .row_i (pp[i*N +: N]),
                .sum_o (row_sum)
            );
            assign acc_s[i-1:0]   = g_stage[i-1].acc_s[i-1:0];
            assign acc_s[i+N:i]   = row_sum;
            if (i + N + 1 <= PW - 1) begin : g_pad
                assign acc_s[PW-1:i+N+1] = '0;
            end
        end
    end

    assign raw_sum = g_stage[N-1].acc_s;
    // Signed mode: the top bit carries negative weight, realised by flipping it
    assign prod_c  = {raw_sum[PW-1] ^ is_signed, raw_sum[PW-2:0]};

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                product_o <= '0;
            end else begin
                product_o <= prod_c;
            end
        end
    end else begin : g_comb
        assign product_o = prod_c;
    end
endmodule

// File: rtl/tc_array_mult_chk.sv
module tc_array_mult_chk #(
    parameter int N       = 8,
    parameter bit OUT_REG = 1'b1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mode_i,
    input logic [N-1:0]   a_i,
    input logic [N-1:0]   b_i,
    input logic [2*N-1:0] product_o
);
    localparam int PW = 2 * N;

    logic         primed;
    logic         m_v;
    logic [N-1:0] a_v;
    logic [N-1:0] b_v;

    if (OUT_REG) begin : g_track
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                primed <= 1'b0;
                m_v    <= 1'b0;
                a_v    <= '0;
                b_v    <= '0;
            end else begin
                primed <= 1'b1;
                m_v    <= mode_i;
                a_v    <= a_i;
                b_v    <= b_i;
            end
        end

        property p_reset_clear;
            @(posedge clk) !rst_n |=> product_o == '0;
        endproperty
        AST_RESET_CLEAR: assert property (p_reset_clear); // R7
    end else begin : g_direct
        assign primed = 1'b1;
        assign m_v    = mode_i;
        assign a_v    = a_i;
        assign b_v    = b_i;
    end

    logic [PW-1:0]        ref_u;
    logic signed [PW-1:0] sa;
    logic signed [PW-1:0] sb;
    logic signed [PW-1:0] ref_s;
    logic [N-1:0]         most_neg;

    assign ref_u    = PW'(a_v) * PW'(b_v);
    assign sa       = {{N{a_v[N-1]}}, a_v};
    assign sb       = {{N{b_v[N-1]}}, b_v};
    assign ref_s    = sa * sb;
    assign most_neg = {1'b1, {(N-1){1'b0}}};

    property p_unsigned;
        @(posedge clk) disable iff (!rst_n) (primed && !m_v) |-> product_o == ref_u;
    endproperty
    property p_signed;
        @(posedge clk) disable iff (!rst_n) (primed && m_v) |-> product_o == ref_s;
    endproperty
    property p_zero;
        @(posedge clk) disable iff (!rst_n) (primed && (a_v == '0 || b_v == '0)) |-> product_o == '0;
    endproperty
    property p_most_neg;
        @(posedge clk) disable iff (!rst_n)
            (primed && m_v && a_v == most_neg && b_v == most_neg) |-> $onehot0(product_o) && product_o[PW-2];
    endproperty

    AST_UNSIGNED_MATCH: assert property (p_unsigned); // R1
    AST_SIGNED_MATCH:   assert property (p_signed);   // R2
    AST_ZERO_OPERAND:   assert property (p_zero);     // R3
    AST_MOST_NEG_SQR:   assert property (p_most_neg); // R4
endmodule

bind tc_array_mult tc_array_mult_chk #(.N(N), .OUT_REG(OUT_REG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .product_o (product_o)
);

// File: tb/tc_array_mult_bench.sv
`timescale 1ns/1ps
module tc_array_mult_bench;

    localparam int N8 = 8;
    localparam int N4 = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           m8 = 1'b0;
    logic [N8-1:0]  a8 = '0;
    logic [N8-1:0]  b8 = '0;
    logic [2*N8-1:0] p8;
    logic           m4 = 1'b0;
    logic [N4-1:0]  a4 = '0;
    logic [N4-1:0]  b4 = '0;
    logic [2*N4-1:0] p4;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tc_array_mult #(.N(N8), .OUT_REG(1'b1)) u_tc_array_mult (
        .clk(clk), .rst_n(rst_n), .mode_i(m8), .a_i(a8), .b_i(b8), .product_o(p8)
    );
    tc_array_mult #(.N(N4), .OUT_REG(1'b0)) u_tc_array_mult_n4 (
        .clk(clk), .rst_n(rst_n), .mode_i(m4), .a_i(a4), .b_i(b4), .product_o(p4)
    );

    // {mode, a, b, expected} at N = 8
    localparam int NV = 12;
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 8'h00, 8'h5A, 16'h0000},   // R3
        {1'b1, 8'h80, 8'h00, 16'h0000},   // R3
        {1'b0, 8'hFF, 8'hFF, 16'hFE01},   // R5
        {1'b1, 8'h80, 8'h80, 16'h4000},   // R4
        {1'b0, 8'h80, 8'h80, 16'h4000},   // R1
        {1'b1, 8'hFF, 8'hFF, 16'h0001},   // R2
        {1'b1, 8'h80, 8'h7F, 16'hC080},   // R2
        {1'b1, 8'hFF, 8'h80, 16'h0080},   // R2
        {1'b1, 8'h7F, 8'h7F, 16'h3F01},   // R6
        {1'b0, 8'h7F, 8'h7F, 16'h3F01},   // R6
        {1'b1, 8'h01, 8'h9C, 16'hFF9C},   // R8
        {1'b0, 8'h01, 8'h9C, 16'h009C}    // R8
    };

    function automatic longint unsigned ref_prod(bit m, longint unsigned a, longint unsigned b, int n);
        longint sa = longint'(a);
        longint sb = longint'(b);
        longint unsigned mask = (64'd1 << (2 * n)) - 1;
        if (m && a[n-1]) sa = sa - (longint'(1) << n);
        if (m && b[n-1]) sb = sb - (longint'(1) << n);
        return longint'(sa * sb) & mask;
    endfunction

    task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply8(input bit m, input logic [N8-1:0] a, input logic [N8-1:0] b);
        @(negedge clk);
        m8 = m; a8 = a; b8 = b;
        @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // Reset state: R7
        repeat (3) @(negedge clk);
        check("R7 reset", p8, 0);
        m8 = 1'b0; a8 = 8'hFF; b8 = 8'hFF;
        @(negedge clk);
        check("R7 held in reset", p8, 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R7 captured at edge", p8, 16'hFE01);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            apply8(VEC[v][32], VEC[v][31:24], VEC[v][23:16]);
            check($sformatf("vector %0d (R1 R2 R3 R4 R5 R6 R8)", v), p8, VEC[v][15:0]);
        end

        // R7 latency: new operands are not visible before the edge
        @(negedge clk);
        m8 = 1'b0; a8 = 8'h03; b8 = 8'h05;
        #1;
        check("R7 no early update", p8, 16'h009C);
        @(negedge clk);
        check("R7 one-edge latency", p8, 16'h000F);

        // R7 asynchronous clear mid-cycle
        #0.5 rst_n = 1'b0;
        #0.5;
        check("R7 async clear", p8, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2 exhaustive at N = 4, combinational instance
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    m4 = m[0]; a4 = a[3:0]; b4 = b[3:0];
                    #1;
                    check(m ? "R2 n4 sweep" : "R1 n4 sweep", p4, ref_prod(m[0], a, b, N4));
                end
            end
        end

        // R1 / R2 random at N = 8
        for (int k = 0; k < 2000; k++) begin
            logic [N8-1:0] ra;
            logic [N8-1:0] rb;
            bit rm;
            ra = N8'($urandom);
            rb = N8'($urandom);
            rm = k[0];
            apply8(rm, ra, rb);
            check(rm ? "R2 random" : "R1 random", p8, ref_prod(rm, ra, rb, N8));
        end

        // R6: both top bits clear, modes agree
        apply8(1'b1, 8'h35, 8'h6B);
        check("R6 signed", p8, 16'h1627);
        apply8(1'b0, 8'h35, 8'h6B);
        check("R6 unsigned", p8, 16'h1627);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule